// File: doc/BRIEF.md
# Word-Serial Radix-2 Montgomery Multiplier

This block computes the Montgomery product X·Y·2^-m mod M for m-bit operands. A single adder, w+2 bits wide, does all the arithmetic. The three operands are loaded one w-bit word at a time into small word-addressed stores. A start pulse launches the run. The block then takes X one bit at a time, from bit 0 upward. For each bit it sweeps the words of Y, M and the running sum S, and it folds the one-bit right shift of S into that sweep. After the last bit of X, a pass from the least significant word works out the borrow of S−M. A second pass writes S−M, but only when that borrow is zero.

The load side is a valid/ready stream. A word is taken on any clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is low for the whole run, so the producer must hold its word until the run ends. The result is read through an address port with one cycle of latency, and it stays unchanged until the next accepted start. Operands persist across runs.

With `NW = m/w + 2` storage words, a run takes NW·(m+1) cycles. A run that needs the final subtraction takes NW·(m+2) cycles. The inputs must satisfy X < M, Y < M, and M odd.

Top module: `mont_mul_ws`

## Requirements
- R1: After `done`, the result words read back form (X·Y·2^-m) mod M, for odd M and X, Y < M.
- R2: A word is written on a clock edge with `ld_valid` and `ld_ready` both high. `ld_sel` picks the target: 0 = X, 1 = Y, 2 = M. `ld_addr` is the word index, with word 0 the least significant.
- R3: `busy` is high and `ld_ready` is low from the edge that accepts `start` until `done`. Words offered during that window are not taken and do not change the operands.
- R4: A `start` raised while busy does not restart the run and does not stretch it.
- R5: `done` is a one-cycle pulse. It rises NW·(m+1) cycles after the edge that accepted `start`. When the final subtraction pass is needed, it rises NW·(m+2) cycles after that edge instead.
- R6: When the sum left after the last bit of X is at least M, the result is that sum minus M, taken once.
- R7: Loads with `ld_sel` = 3, or with `ld_addr` ≥ m/w, are dropped.
- R8: `rd_data` shows, one cycle later, the result word addressed by `rd_addr`. The words held stay unchanged while the block is idle. Words at index m/w and above read as 0 after a run.
- R9: After reset, `busy` = 0, `done` = 0, `ld_ready` = 1 and every result word reads 0.
- R10: A second start without reloading reproduces the same result, because each run clears S first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a run when the block is idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word can be taken (idle) |
| ld_sel | input | 2 | Load target: 0 X, 1 Y, 2 M, 3 none |
| ld_addr | input | AW | Load word index |
| ld_data | input | W | Load word value |
| rd_addr | input | AW | Result word index |
| rd_data | output | W | Result word, registered, one cycle after `rd_addr` |

## Verification
The bench computes each run's length independently. It repeats the bit-serial recurrence to learn whether the subtraction pass is due, and so expects `done` exactly NW·(m+1) or NW·(m+2) cycles after the accepting edge. It counts falling edges from that edge and compares the count to the expected length. The falling edge after `done` must show `done` low again. Result words are read by setting `rd_addr` on one falling edge and sampling `rd_data` on the next, which leaves room for the single output register. Stimulus is driven only on falling edges, so every check lands half a period after the edge that produced it.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MUL  = 2'd1,
    PH_CMP  = 2'd2,
    PH_SUB  = 2'd3
  } mont_phase_e;

  localparam int N_OPS = 3;  // X, Y, M stores, selected by ld_sel 0..2
endpackage

// File: rtl/mont_opmem.sv
module mont_opmem #(
  parameter int W          = 8,
  parameter int DEPTH      = 4,
  parameter int LOAD_WORDS = 2,
  parameter int AW         = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_word,
  output logic [W-1:0]  word0
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_word = ({1'b0, rd_addr} < (AW+1)'(DEPTH)) ? mem[rd_addr] : '0;
  assign word0   = mem[0];

  // R7: the top must never let a write reach the zero-extension words
  p_load_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < (AW+1)'(LOAD_WORDS)));
endmodule

// File: rtl/mont_word_alu.sv
module mont_word_alu #(
  parameter int W = 8
) (
  input  logic         xbit,
  input  logic         qi,
  input  logic [W-1:0] y_word,
  input  logic [W-1:0] m_word,
  input  logic [W-1:0] s_word,
  input  logic [1:0]   cin,
  input  logic         bin,
  output logic [W+1:0] sum,
  output logic [W-1:0] diff,
  output logic         bout
);
  logic [W:0] sub_full;

  always_comb begin
    sum = (W+2)'(xbit ? y_word : '0)
        + (W+2)'(qi ? m_word : '0)
        + (W+2)'(s_word)
        + (W+2)'(cin);
    sub_full = {1'b0, s_word} - {1'b0, m_word} - (W+1)'(bin);
    diff = sub_full[W-1:0];
    bout = sub_full[W];
  end
endmodule

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
#(
  parameter int M_BITS = 2048,
  parameter int NW     = 258,
  parameter int IW     = 11,
  parameter int AW     = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          last_borrow,
  output mont_phase_e   phase,
  output logic [IW-1:0] i_cnt,
  output logic [AW-1:0] j_cnt,
  output logic          j_last,
  output logic          start_acc,
  output logic          busy,
  output logic          done
);
  logic i_last;

  assign j_last    = (j_cnt == AW'(NW - 1));
  assign i_last    = (i_cnt == IW'(M_BITS - 1));
  assign start_acc = (phase == PH_IDLE) && start;
  assign busy      = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      i_cnt <= '0;
      j_cnt <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_MUL;
          i_cnt <= '0;
          j_cnt <= '0;
        end
        PH_MUL: if (j_last) begin
          j_cnt <= '0;
          if (i_last) phase <= PH_CMP;
          else        i_cnt <= i_cnt + 1'b1;
        end else begin
          j_cnt <= j_cnt + 1'b1;
        end
        PH_CMP: if (j_last) begin
          j_cnt <= '0;
          if (last_borrow) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            phase <= PH_SUB;
          end
        end else begin
          j_cnt <= j_cnt + 1'b1;
        end
        PH_SUB: if (j_last) begin
          j_cnt <= '0;
          phase <= PH_IDLE;
          done  <= 1'b1;
        end else begin
          j_cnt <= j_cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: completion only follows a compare or subtract pass
  p_done_after_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phase == PH_CMP || phase == PH_SUB));
  // R4: a start during a run does not rewind the bit counter
  p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MUL && start && i_cnt != '0) |=> (i_cnt != '0));
endmodule

// File: rtl/mont_mul_ws.sv
module mont_mul_ws
  import mont_pkg::*;
#(
  parameter int M_BITS = 2048,
  parameter int W      = 8,
  localparam int AW    = $clog2(M_BITS / W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [1:0]    ld_sel,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int OP_WORDS = M_BITS / W;
  localparam int NW       = OP_WORDS + 2;
  localparam int IW       = $clog2(M_BITS);
  localparam int LW       = $clog2(W);

  mont_phase_e   phase;
  logic [IW-1:0] i_cnt;
  logic [AW-1:0] j_cnt;
  logic          j_last, start_acc;

  logic [W-1:0]  s_mem [NW];
  logic [1:0]    c_r;
  logic          qi_r, bor_r;

  logic [AW-1:0] op_rd_addr [N_OPS];
  logic [W-1:0]  op_rd_word [N_OPS];
  logic [W-1:0]  op_word0   [N_OPS];
  logic [N_OPS-1:0] op_wr_en;
  logic          addr_ok;

  logic [AW-1:0] x_addr;
  logic          x_bit, qi_now, qi_use;
  logic [1:0]    cin;
  logic [W+1:0]  alu_sum;
  logic [W-1:0]  alu_diff;
  logic          alu_bout;

  assign ld_ready = !busy;
  assign addr_ok  = ({1'b0, ld_addr} < (AW+1)'(OP_WORDS));
  assign x_addr   = AW'(i_cnt >> LW);

  // one word store per operand; X is addressed by bit position, Y and M by word step
  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    assign op_wr_en[g]   = ld_valid && ld_ready && addr_ok && (ld_sel == 2'(g));
    assign op_rd_addr[g] = (g == 0) ? x_addr : j_cnt;
    mont_opmem #(.W(W), .DEPTH(NW), .LOAD_WORDS(OP_WORDS), .AW(AW)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (op_wr_en[g]),
      .wr_addr (ld_addr),
      .wr_data (ld_data),
      .rd_addr (op_rd_addr[g]),
      .rd_word (op_rd_word[g]),
      .word0   (op_word0[g])
    );
  end

  assign x_bit  = op_rd_word[0][i_cnt[LW-1:0]];
  assign qi_now = (x_bit & op_word0[1][0]) ^ s_mem[0][0];
  assign qi_use = (j_cnt == '0) ? qi_now : qi_r;
  assign cin    = (j_cnt == '0) ? 2'b00 : c_r;

  mont_word_alu #(.W(W)) u_alu (
    .xbit   (x_bit),
    .qi     (qi_use),
    .y_word (op_rd_word[1]),
    .m_word (op_rd_word[2]),
    .s_word (s_mem[j_cnt]),
    .cin    (cin),
    .bin    (bor_r),
    .sum    (alu_sum),
    .diff   (alu_diff),
    .bout   (alu_bout)
  );

  mont_ctrl #(.M_BITS(M_BITS), .NW(NW), .IW(IW), .AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .last_borrow (alu_bout),
    .phase       (phase),
    .i_cnt       (i_cnt),
    .j_cnt       (j_cnt),
    .j_last      (j_last),
    .start_acc   (start_acc),
    .busy        (busy),
    .done        (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NW; k++) s_mem[k] <= '0;
      c_r   <= '0;
      qi_r  <= 1'b0;
      bor_r <= 1'b0;
    end else if (start_acc) begin
      for (int k = 0; k < NW; k++) s_mem[k] <= '0;
      c_r   <= '0;
      qi_r  <= 1'b0;
      bor_r <= 1'b0;
    end else begin
      unique case (phase)
        PH_MUL: begin
          if (j_cnt == '0) begin
            qi_r     <= qi_now;
            c_r      <= alu_sum[W+1:W];
            s_mem[0] <= alu_sum[W-1:0];
          end else begin
            c_r                  <= j_last ? 2'b00 : alu_sum[W+1:W];
            s_mem[j_cnt]         <= j_last ? '0 : alu_sum[W-1:0];
            s_mem[j_cnt - 1'b1]  <= {alu_sum[0], s_mem[j_cnt - 1'b1][W-1:1]};
          end
        end
        PH_CMP: bor_r <= j_last ? 1'b0 : alu_bout;
        PH_SUB: begin
          s_mem[j_cnt] <= alu_diff;
          bor_r        <= j_last ? 1'b0 : alu_bout;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= ({1'b0, rd_addr} < (AW+1)'(NW)) ? s_mem[rd_addr] : '0;
  end

  // R1: with X, Y < M the partial sum never reaches the top zero-extension word
  p_top_word_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MUL && j_last) |-> (alu_sum == '0));
  // R8: the held result does not move while idle and not restarted
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(s_mem[0]));
endmodule

// File: tb/mont_mul_ws_tb.sv
module mont_mul_ws_tb;
  localparam int MB  = 24;
  localparam int WW  = 4;
  localparam int OPW = MB / WW;
  localparam int NWB = OPW + 2;
  localparam int AWB = $clog2(NWB);
  localparam int LAT_PLAIN = NWB * (MB + 1);
  localparam int LAT_SUB   = NWB * (MB + 2);
  localparam int NVEC = 8;

  localparam logic [23:0] TM [NVEC] = '{24'hF3A5C7, 24'hFFFFFF, 24'h000003, 24'h800001,
                                        24'hC00005, 24'h9E3779, 24'hABCDEF, 24'h00A5A5};
  localparam logic [23:0] TX [NVEC] = '{24'h123456, 24'hFFFFFE, 24'h000001, 24'h000000,
                                        24'h000001, 24'h9E3778, 24'h5A5A5A, 24'h00A5A4};
  localparam logic [23:0] TY [NVEC] = '{24'h0ABCDE, 24'hFFFFFE, 24'h000002, 24'h7FFFFF,
                                        24'h000001, 24'h000001, 24'h3C3C3C, 24'h001234};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ld_valid = 1'b0;
  logic [1:0] ld_sel = 2'd0;
  logic [AWB-1:0] ld_addr = '0;
  logic [WW-1:0] ld_data = '0;
  logic [AWB-1:0] rd_addr = '0;
  logic busy, done, ld_ready;
  logic [WW-1:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  mont_mul_ws #(.M_BITS(MB), .W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected < 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  function automatic longint raw_mont(input longint x, input longint y, input longint m);
    longint s = 0;
    for (int i = 0; i < MB; i++) begin
      longint t = s + (((x >> i) & 1) != 0 ? y : 0);
      if ((t & 1) != 0) t += m;
      s = t >> 1;
    end
    return s;
  endfunction

  function automatic longint ref_mont(input longint x, input longint y, input longint m);
    longint r = (x * y) % m;
    for (int i = 0; i < MB; i++) begin
      if ((r & 1) != 0) r += m;
      r = r >> 1;
    end
    return r;
  endfunction

  task automatic load_word(input logic [1:0] sel, input int addr, input logic [WW-1:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = sel; ld_addr = AWB'(addr); ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic load_op(input logic [1:0] sel, input logic [23:0] v);
    for (int k = 0; k < OPW; k++) load_word(sel, k, v[k*WW +: WW]);
  endtask

  task automatic read_result(output longint res, output bit upper_zero);
    res = 0; upper_zero = 1'b1;
    for (int k = 0; k < NWB; k++) begin
      @(negedge clk); rd_addr = AWB'(k);
      @(negedge clk);
      if (k < OPW) res |= longint'(rd_data) << (k * WW);
      else if (rd_data != '0) upper_zero = 1'b0;
    end
  endtask

  // launches a run; disturb raises start and offers an X word mid-run (R3, R4)
  task automatic run(input bit disturb, output int lat);
    int cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && cnt < 5000) begin
      if (disturb && cnt == 40) begin
        check(ld_ready == 1'b0 && busy == 1'b1, "R3 ready low while busy", ld_ready, 0);
        start = 1'b1; ld_valid = 1'b1; ld_sel = 2'd0; ld_addr = '0; ld_data = '1;
      end else begin
        start = 1'b0; ld_valid = 1'b0;
      end
      @(negedge clk); cnt++;
    end
    start = 1'b0; ld_valid = 1'b0;
    lat = cnt;
    @(negedge clk);
    check(done == 1'b0, "R5 done lasts one cycle", done, 0);
  endtask

  task automatic run_check(input logic [23:0] x, input logic [23:0] y, input logic [23:0] m,
                           input bit disturb, input string tag);
    longint raw = raw_mont(longint'(x), longint'(y), longint'(m));
    longint exp = (raw >= longint'(m)) ? raw - longint'(m) : raw;
    longint res;
    bit uz;
    int lat;
    run(disturb, lat);
    check(lat == ((raw >= longint'(m)) ? LAT_SUB : LAT_PLAIN), {"R5 latency ", tag}, lat,
          (raw >= longint'(m)) ? LAT_SUB : LAT_PLAIN);
    read_result(res, uz);
    if (raw >= longint'(m)) check(res == exp, {"R6 subtracted result ", tag}, res, exp);
    else                    check(res == exp, {"R1 result ", tag}, res, exp);
    check(exp == ref_mont(longint'(x), longint'(y), longint'(m)), {"R1 reference ", tag},
          exp, ref_mont(longint'(x), longint'(y), longint'(m)));
    check(uz, {"R8 upper words zero ", tag}, uz, 1);
  endtask

  initial begin
    longint r0, r1;
    bit uz;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy == 1'b0 && done == 1'b0, "R9 idle after reset", {busy, done}, 0);
    check(ld_ready == 1'b1, "R9 ready after reset", ld_ready, 1);
    read_result(r0, uz);
    check(r0 == 0 && uz, "R9 result words zero", r0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ld_ready == 1'b1, "R9 ready after release", ld_ready, 1);

    // table walk: R1, R2, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      load_op(2'd0, TX[v]); load_op(2'd1, TY[v]); load_op(2'd2, TM[v]);
      run_check(TX[v], TY[v], TM[v], 1'b0, $sformatf("vec%0d", v));
    end

    // R10: rerun without reload gives the same words
    read_result(r0, uz);
    run_check(TX[NVEC-1], TY[NVEC-1], TM[NVEC-1], 1'b0, "R10 rerun");
    read_result(r1, uz);
    check(r1 == r0, "R10 same result on rerun", r1, r0);

    // R8: result holds while idle
    repeat (25) @(negedge clk);
    read_result(r1, uz);
    check(r1 == r0, "R8 result held while idle", r1, r0);

    // R7: dropped loads (sel 3, and address past the operand words)
    load_word(2'd3, 0, 4'hF);
    load_word(2'd1, OPW, 4'hF);
    load_word(2'd2, OPW + 1, 4'hF);
    run_check(TX[NVEC-1], TY[NVEC-1], TM[NVEC-1], 1'b0, "R7 dropped loads");

    // R3, R4: start and load offered mid-run are ignored
    load_op(2'd0, TX[0]); load_op(2'd1, TY[0]); load_op(2'd2, TM[0]);
    run_check(TX[0], TY[0], TM[0], 1'b1, "R3 R4 disturbed");
    run_check(TX[0], TY[0], TM[0], 1'b0, "R3 operands intact");

    // random odd moduli
    for (int n = 0; n < 16; n++) begin
      logic [23:0] m, x, y;
      lfsr = rnd(lfsr); m = lfsr[23:0] | 24'h1;
      if (m < 24'd3) m = 24'd3;
      lfsr = rnd(lfsr); x = 24'(longint'(lfsr[23:0]) % longint'(m));
      lfsr = rnd(lfsr); y = 24'(longint'(lfsr[23:0]) % longint'(m));
      load_op(2'd0, x); load_op(2'd1, y); load_op(2'd2, m);
      run_check(x, y, m, 1'b0, $sformatf("R1 rand%0d", n));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule